// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node side of a directory-based coherence scheme for a distributed shared memory machine. For every memory block it owns, it keeps a directory entry and the block's data in a small local memory array. Each directory entry holds a coherence state and one presence bit per processor. Caches send it read misses, write misses, data write-backs and invalidation acknowledgements. It answers with point-to-point invalidates, fetches, fetch-with-invalidates and data replies. Nothing is ever broadcast.

The controller serves one request at a time. A miss that needs no remote action is answered at once. A miss that hits a block held elsewhere parks the controller in a busy phase. In that phase it first issues the invalidates or the fetch. It then collects every acknowledgement or the owner's write-back, and only then sends the data reply and commits the new directory entry. Three channels carry the messages: a request channel in, a response channel in (write-backs and acknowledgements), and one message channel out. Each uses a valid/ready handshake. A combinational lookup port exposes the directory entry and the stored data for any block.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block reads back as uncached (lookup state code 0; shared is 1, exclusive is 2) with an all-zero presence vector and zero data. No outgoing message is valid and a request can be accepted.
- R2: A read miss (request kind 0) from processor P to an uncached or shared block returns a data reply (message kind 3) to P carrying the stored data. P's presence bit is added and the block becomes shared.
- R3: A write miss (request kind 1) from P to an uncached block returns a data reply to P. The presence vector becomes only P and the block becomes exclusive.
- R4: A write miss from P to a shared block sends one invalidate (message kind 0) to each sharer other than P, in ascending processor number. It sends no reply until one acknowledgement (response kind 1) per invalidate has arrived. It then replies to P and leaves the block exclusive with only P present. If P is the only sharer, it replies at once.
- R5: A read miss from P to an exclusive block sends a fetch (message kind 1) to the owner. The owner's write-back (response kind 0) is stored in memory and forwarded to P in the reply. The block becomes shared with both the owner and P present.
- R6: A write miss from P to an exclusive block sends a fetch-with-invalidate (message kind 2) to the owner. The returned data is stored in memory and sent to P. The block stays exclusive with only P present.
- R7: A write-back that arrives while the controller is idle stores its data and makes the block uncached with an empty presence vector.
- R8: From the cycle a request is accepted until its reply has been taken, no further request is accepted.
- R9: An outgoing message that is valid but not taken keeps its valid, kind, destination, address and data unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Controller takes the request |
| req_kind | input | 1 | 0 read miss, 1 write miss |
| req_proc | input | PROC_W | Requesting processor |
| req_addr | input | ADDR_W | Block number |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Controller takes the response |
| rsp_kind | input | 1 | 0 data write-back, 1 invalidate acknowledgement |
| rsp_proc | input | PROC_W | Responding processor |
| rsp_addr | input | ADDR_W | Block number |
| rsp_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply |
| msg_dst | output | PROC_W | Destination processor |
| msg_addr | output | ADDR_W | Block number |
| msg_data | output | DATA_W | Reply data, zero otherwise |
| look_addr | input | ADDR_W | Block to inspect |
| look_state | output | 2 | Directory state of that block |
| look_sharers | output | N_PROC | Presence vector of that block |
| look_data | output | DATA_W | Stored data of that block |

## Verification
The checks assume that the caches behave: each invalidate draws exactly one acknowledgement for the same block, a fetch is answered only by the owner's write-back, and unsolicited write-backs come only from the exclusive owner while no request is in flight. The bench acts as every remote cache. It issues a response only after it has taken the message that asks for it, and it keeps idle write-backs apart from open requests. It also holds messages back on purpose to exercise the hold rule and the wait for acknowledgements.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      DS_UNC = 2'd0,
      DS_SHR = 2'd1,
      DS_EXC = 2'd2
   } dstate_t;

   typedef enum logic [1:0] {
      MK_INV       = 2'd0,
      MK_FETCH     = 2'd1,
      MK_FETCH_INV = 2'd2,
      MK_REPLY     = 2'd3
   } mkind_t;

   typedef enum logic [2:0] {
      F_IDLE,
      F_INV,
      F_ACKW,
      F_FETCH,
      F_DATAW,
      F_REPLY
   } fsm_t;

   localparam logic RK_READ  = 1'b0;
   localparam logic RK_WRITE = 1'b1;
   localparam logic RSP_WB   = 1'b0;
   localparam logic RSP_ACK  = 1'b1;
endpackage

// File: rtl/dir_pick_first.sv
module dir_pick_first #(
   parameter int N   = 4,
   parameter int IDX = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]   mask,
   output logic [IDX-1:0] idx,
   output logic           any
);
   logic [N-1:0] hit;

   // hit[g] is set for the lowest set bit only
   for (genvar g = 0; g < N; g++) begin : g_hit
      if (g == 0) begin : g_first
         assign hit[g] = mask[g];
      end else begin : g_rest
         assign hit[g] = mask[g] && (mask[g-1:0] == '0);
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (hit[i]) idx = IDX'(i);
      end
   end

   assign any = |mask;
endmodule

// File: rtl/dir_entry_table.sv
module dir_entry_table #(
   parameter int N_PROC = 4,
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [1:0]        rd_state,
   output logic [N_PROC-1:0] rd_sharers,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic [1:0]        lk_state,
   output logic [N_PROC-1:0] lk_sharers,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_state,
   input  logic [N_PROC-1:0] wr_sharers
);
   logic [1:0]        st_q [DEPTH];
   logic [N_PROC-1:0] sh_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[e] <= dir_pkg::DS_UNC;
            sh_q[e] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(e))) begin
            st_q[e] <= wr_state;
            sh_q[e] <= wr_sharers;
         end
      end
   end

   assign rd_state   = st_q[rd_addr];
   assign rd_sharers = sh_q[rd_addr];
   assign lk_state   = st_q[lk_addr];
   assign lk_sharers = sh_q[lk_addr];
endmodule

// File: rtl/dir_data_mem.sv
module dir_data_mem #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter bit MEM_CLEAR = 1'b1,
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   if (MEM_CLEAR) begin : g_clear
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n) mem_q[w] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(w))) mem_q[w] <= wr_data;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (wr_en) mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_addr];
   assign lk_data = mem_q[lk_addr];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
   parameter int N_PROC    = 4,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter bit MEM_CLEAR = 1'b1,
   localparam int PROC_W   = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int CNT_W    = $clog2(N_PROC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_kind,
   input  logic [PROC_W-1:0] req_proc,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic              rsp_kind,
   input  logic [PROC_W-1:0] rsp_proc,
   input  logic [ADDR_W-1:0] rsp_addr,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [1:0]        msg_kind,
   output logic [PROC_W-1:0] msg_dst,
   output logic [ADDR_W-1:0] msg_addr,
   output logic [DATA_W-1:0] msg_data,
   input  logic [ADDR_W-1:0] look_addr,
   output logic [1:0]        look_state,
   output logic [N_PROC-1:0] look_sharers,
   output logic [DATA_W-1:0] look_data
);
   import dir_pkg::*;

   if (N_PROC < 2) begin : g_bad_nproc
      $error("dir_home_ctrl: N_PROC must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("dir_home_ctrl: ADDR_W must lie in 1..12");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dir_home_ctrl: DATA_W must be positive");
   end

   function automatic logic [CNT_W-1:0] pop_cnt(input logic [N_PROC-1:0] v);
      logic [CNT_W-1:0] c;
      c = '0;
      for (int i = 0; i < N_PROC; i++) c = c + CNT_W'(v[i]);
      return c;
   endfunction

   fsm_t              st_q;
   logic              kind_q;
   logic [PROC_W-1:0] proc_q;
   logic [PROC_W-1:0] tgt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [N_PROC-1:0] pend_q;
   logic [N_PROC-1:0] nsh_q;
   logic [1:0]        nst_q;
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  ack_left;

   logic [1:0]        ent_st;
   logic [N_PROC-1:0] ent_sh;
   logic [DATA_W-1:0] mem_rd;
   logic [N_PROC-1:0] req_bit;
   logic [N_PROC-1:0] targets;
   logic [PROC_W-1:0] owner;
   logic              owner_any;
   logic [PROC_W-1:0] inv_dst;
   logic              inv_any;
   logic [N_PROC-1:0] pend_nx;

   logic              idle;
   logic              req_fire;
   logic              rsp_fire;
   logic              msg_fire;
   logic              ack_hit;
   logic              wb_hit;

   logic              tbl_wr_en;
   logic [ADDR_W-1:0] tbl_wr_addr;
   logic [1:0]        wr_state;
   logic [N_PROC-1:0] wr_sharers;
   logic              mem_wr_en;
   logic [ADDR_W-1:0] mem_wr_addr;

   assign idle      = (st_q == F_IDLE);
   assign req_ready = idle && !rsp_valid;
   assign rsp_ready = idle || (st_q == F_INV) || (st_q == F_ACKW) || (st_q == F_DATAW);
   assign req_fire  = req_valid && req_ready;
   assign rsp_fire  = rsp_valid && rsp_ready;
   assign msg_fire  = msg_valid && msg_ready;

   assign req_bit = N_PROC'(1) << req_proc;
   assign targets = ent_sh & ~req_bit;

   assign ack_hit = rsp_fire && (rsp_kind == RSP_ACK) && (rsp_addr == addr_q)
                    && ((st_q == F_INV) || (st_q == F_ACKW)) && (ack_left != '0);
   assign wb_hit  = rsp_fire && (rsp_kind == RSP_WB) && (st_q == F_DATAW)
                    && (rsp_addr == addr_q) && (rsp_proc == tgt_q);

   dir_entry_table #(
      .N_PROC (N_PROC),
      .ADDR_W (ADDR_W)
   ) i_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_addr    (req_addr),
      .rd_state   (ent_st),
      .rd_sharers (ent_sh),
      .lk_addr    (look_addr),
      .lk_state   (look_state),
      .lk_sharers (look_sharers),
      .wr_en      (tbl_wr_en),
      .wr_addr    (tbl_wr_addr),
      .wr_state   (wr_state),
      .wr_sharers (wr_sharers)
   );

   dir_data_mem #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MEM_CLEAR (MEM_CLEAR)
   ) i_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (req_addr),
      .rd_data (mem_rd),
      .lk_addr (look_addr),
      .lk_data (look_data),
      .wr_en   (mem_wr_en),
      .wr_addr (mem_wr_addr),
      .wr_data (rsp_data)
   );

   dir_pick_first #(.N(N_PROC), .IDX(PROC_W)) i_pick_owner (
      .mask (ent_sh),
      .idx  (owner),
      .any  (owner_any)
   );

   dir_pick_first #(.N(N_PROC), .IDX(PROC_W)) i_pick_inv (
      .mask (pend_q),
      .idx  (inv_dst),
      .any  (inv_any)
   );

   assign pend_nx = pend_q & ~(N_PROC'(1) << inv_dst);

   // directory write: idle write-back or commit at reply handshake
   assign tbl_wr_en   = (idle && rsp_fire && (rsp_kind == RSP_WB))
                        || ((st_q == F_REPLY) && msg_fire);
   assign tbl_wr_addr = idle ? rsp_addr : addr_q;
   assign wr_state    = idle ? DS_UNC : nst_q;
   assign wr_sharers  = idle ? '0 : nsh_q;

   assign mem_wr_en   = (idle && rsp_fire && (rsp_kind == RSP_WB)) || wb_hit;
   assign mem_wr_addr = idle ? rsp_addr : addr_q;

   always_comb begin
      msg_valid = 1'b0;
      msg_kind  = MK_INV;
      msg_dst   = '0;
      msg_addr  = addr_q;
      msg_data  = '0;
      case (st_q)
         F_INV: begin
            msg_valid = inv_any;
            msg_kind  = MK_INV;
            msg_dst   = inv_dst;
         end
         F_FETCH: begin
            msg_valid = 1'b1;
            msg_kind  = (kind_q == RK_WRITE) ? MK_FETCH_INV : MK_FETCH;
            msg_dst   = tgt_q;
         end
         F_REPLY: begin
            msg_valid = 1'b1;
            msg_kind  = MK_REPLY;
            msg_dst   = proc_q;
            msg_data  = data_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= F_IDLE;
         kind_q <= RK_READ;
         proc_q <= '0;
         tgt_q  <= '0;
         addr_q <= '0;
         pend_q <= '0;
         nsh_q  <= '0;
         nst_q  <= DS_UNC;
         data_q <= '0;
      end else begin
         case (st_q)
            F_IDLE: begin
               if (req_fire) begin
                  kind_q <= req_kind;
                  proc_q <= req_proc;
                  addr_q <= req_addr;
                  data_q <= mem_rd;
                  if (ent_st == DS_EXC) begin
                     tgt_q <= owner;
                     st_q  <= F_FETCH;
                     if (req_kind == RK_WRITE) begin
                        nst_q <= DS_EXC;
                        nsh_q <= req_bit;
                     end else begin
                        nst_q <= DS_SHR;
                        nsh_q <= ent_sh | req_bit;
                     end
                  end else if (req_kind == RK_WRITE) begin
                     nst_q <= DS_EXC;
                     nsh_q <= req_bit;
                     if ((ent_st == DS_SHR) && (targets != '0)) begin
                        pend_q <= targets;
                        st_q   <= F_INV;
                     end else begin
                        st_q <= F_REPLY;
                     end
                  end else begin
                     nst_q <= DS_SHR;
                     nsh_q <= ((ent_st == DS_SHR) ? ent_sh : '0) | req_bit;
                     st_q  <= F_REPLY;
                  end
               end
            end
            F_INV: begin
               if (msg_fire) begin
                  pend_q <= pend_nx;
                  if (pend_nx == '0) st_q <= F_ACKW;
               end
            end
            F_ACKW: begin
               if (ack_left == '0) st_q <= F_REPLY;
            end
            F_FETCH: begin
               if (msg_fire) st_q <= F_DATAW;
            end
            F_DATAW: begin
               if (wb_hit) begin
                  data_q <= rsp_data;
                  st_q   <= F_REPLY;
               end
            end
            F_REPLY: begin
               if (msg_fire) st_q <= F_IDLE;
            end
            default: st_q <= F_IDLE;
         endcase
      end
   end

   // acknowledgement counter, loaded when invalidations are launched
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_left <= '0;
      end else if (req_fire && (req_kind == RK_WRITE) && (ent_st == DS_SHR)) begin
         ack_left <= pop_cnt(targets);
      end else if (ack_hit) begin
         ack_left <= ack_left - CNT_W'(1);
      end
   end

   logic unused_ok;
   assign unused_ok = owner_any;
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
   parameter int N_PROC = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   localparam int PROC_W = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int CNT_W  = $clog2(N_PROC + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [1:0]        msg_kind,
   input logic [PROC_W-1:0] msg_dst,
   input logic [ADDR_W-1:0] msg_addr,
   input logic [DATA_W-1:0] msg_data,
   input logic [PROC_W-1:0] proc_q,
   input logic [CNT_W-1:0]  ack_left,
   input logic              tbl_wr_en,
   input logic [1:0]        wr_state,
   input logic [N_PROC-1:0] wr_sharers
);
   p_hold_msg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dst)
                                     && $stable(msg_addr) && $stable(msg_data)));

   p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_reply_waits_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && (msg_kind == 2'd3)) |-> (ack_left == '0));

   p_inv_skips_requester_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && (msg_kind == 2'd0)) |-> (msg_dst != proc_q));

   p_excl_single_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_wr_en && (wr_state == 2'd2)) |-> ($countones(wr_sharers) == 1));

   p_uncached_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_wr_en && (wr_state == 2'd0)) |-> (wr_sharers == '0));
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
   .N_PROC (N_PROC),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .msg_valid  (msg_valid),
   .msg_ready  (msg_ready),
   .msg_kind   (msg_kind),
   .msg_dst    (msg_dst),
   .msg_addr   (msg_addr),
   .msg_data   (msg_data),
   .proc_q     (proc_q),
   .ack_left   (ack_left),
   .tbl_wr_en  (tbl_wr_en),
   .wr_state   (wr_state),
   .wr_sharers (wr_sharers)
);

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
   localparam int CLK_P  = 10;
   localparam int N_PROC = 4;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int PROC_W = 2;

   localparam int K_INV = 0, K_FETCH = 1, K_FINV = 2, K_REPLY = 3;
   localparam int S_UNC = 0, S_SHR = 1, S_EXC = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_kind = 1'b0;
   logic [PROC_W-1:0] req_proc = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              rsp_valid = 1'b0;
   logic              rsp_ready;
   logic              rsp_kind = 1'b0;
   logic [PROC_W-1:0] rsp_proc = '0;
   logic [ADDR_W-1:0] rsp_addr = '0;
   logic [DATA_W-1:0] rsp_data = '0;
   logic              msg_valid;
   logic              msg_ready = 1'b0;
   logic [1:0]        msg_kind;
   logic [PROC_W-1:0] msg_dst;
   logic [ADDR_W-1:0] msg_addr;
   logic [DATA_W-1:0] msg_data;
   logic [ADDR_W-1:0] look_addr = '0;
   logic [1:0]        look_state;
   logic [N_PROC-1:0] look_sharers;
   logic [DATA_W-1:0] look_data;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P / 2) clk = ~clk;

   dir_home_ctrl #(
      .N_PROC (N_PROC),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_dir_home_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_proc(req_proc), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
      .rsp_proc(rsp_proc), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
      .msg_dst(msg_dst), .msg_addr(msg_addr), .msg_data(msg_data),
      .look_addr(look_addr), .look_state(look_state),
      .look_sharers(look_sharers), .look_data(look_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_req(input int kind, input int proc, input int addr);
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = kind[0];
      req_proc  = PROC_W'(proc);
      req_addr  = ADDR_W'(addr);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send_rsp(input int kind, input int proc, input int addr, input int data);
      @(negedge clk);
      rsp_valid = 1'b1;
      rsp_kind  = kind[0];
      rsp_proc  = PROC_W'(proc);
      rsp_addr  = ADDR_W'(addr);
      rsp_data  = DATA_W'(data);
      while (!rsp_ready) @(negedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic expect_msg(input int kind, input int dst, input int addr,
                             input int data, input string tag);
      int w = 0;
      @(negedge clk);
      while (!msg_valid && w < 50) begin
         @(negedge clk);
         w++;
      end
      chk(msg_valid, {tag, " msg valid"}, int'(msg_valid), 1);
      chk(msg_kind == kind[1:0], {tag, " msg kind"}, int'(msg_kind), kind);
      chk(msg_dst == dst[PROC_W-1:0], {tag, " msg dst"}, int'(msg_dst), dst);
      chk(msg_addr == addr[ADDR_W-1:0], {tag, " msg addr"}, int'(msg_addr), addr);
      if (kind == K_REPLY)
         chk(msg_data == data[DATA_W-1:0], {tag, " reply data"}, int'(msg_data), data);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic check_entry(input int addr, input int st, input int sh,
                              input int data, input string tag);
      look_addr = ADDR_W'(addr);
      #1;
      chk(look_state == st[1:0], {tag, " state"}, int'(look_state), st);
      chk(look_sharers == sh[N_PROC-1:0], {tag, " sharers"}, int'(look_sharers), sh);
      chk(look_data == data[DATA_W-1:0], {tag, " data"}, int'(look_data), data);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!msg_valid, "R1 no message after reset", int'(msg_valid), 0);
      chk(req_ready, "R1 request accepted after reset", int'(req_ready), 1);
      check_entry(3, S_UNC, 0, 0, "R1 block 3");
      check_entry(15, S_UNC, 0, 0, "R1 block 15");
   endtask

   task automatic t_write_uncached;
      send_req(1, 1, 3);
      expect_msg(K_REPLY, 1, 3, 0, "R3 reply");
      check_entry(3, S_EXC, 4'b0010, 0, "R3 entry");
   endtask

   task automatic t_write_exclusive;
      send_req(1, 2, 3);
      expect_msg(K_FINV, 1, 3, 0, "R6 fetch-inv");
      send_rsp(0, 1, 3, 8'h5A);
      expect_msg(K_REPLY, 2, 3, 8'h5A, "R6 reply");
      check_entry(3, S_EXC, 4'b0100, 8'h5A, "R6 entry");
   endtask

   task automatic t_read_exclusive;
      send_req(0, 0, 3);
      expect_msg(K_FETCH, 2, 3, 0, "R5 fetch");
      send_rsp(0, 2, 3, 8'h77);
      expect_msg(K_REPLY, 0, 3, 8'h77, "R5 reply");
      check_entry(3, S_SHR, 4'b0101, 8'h77, "R5 entry");
   endtask

   task automatic t_read_shared;
      send_req(0, 3, 3);
      expect_msg(K_REPLY, 3, 3, 8'h77, "R2 shared reply");
      check_entry(3, S_SHR, 4'b1101, 8'h77, "R2 shared entry");
   endtask

   task automatic t_write_shared;
      send_req(1, 2, 3);
      expect_msg(K_INV, 0, 3, 0, "R4 first invalidate");
      expect_msg(K_INV, 3, 3, 0, "R4 second invalidate");
      repeat (3) @(negedge clk);
      chk(!msg_valid, "R4 no reply before acks", int'(msg_valid), 0);
      send_rsp(1, 0, 3, 0);
      repeat (3) @(negedge clk);
      chk(!msg_valid, "R4 no reply after one ack", int'(msg_valid), 0);
      send_rsp(1, 3, 3, 0);
      expect_msg(K_REPLY, 2, 3, 8'h77, "R4 reply");
      check_entry(3, S_EXC, 4'b0100, 8'h77, "R4 entry");
   endtask

   task automatic t_idle_writeback;
      send_rsp(0, 2, 3, 8'hC3);
      check_entry(3, S_UNC, 0, 8'hC3, "R7 entry");
      chk(!msg_valid, "R7 no message", int'(msg_valid), 0);
   endtask

   task automatic t_read_uncached_and_sole_sharer;
      send_req(0, 1, 3);
      expect_msg(K_REPLY, 1, 3, 8'hC3, "R2 uncached reply");
      check_entry(3, S_SHR, 4'b0010, 8'hC3, "R2 uncached entry");
      send_req(1, 1, 3);
      expect_msg(K_REPLY, 1, 3, 8'hC3, "R4 sole sharer reply");
      check_entry(3, S_EXC, 4'b0010, 8'hC3, "R4 sole sharer entry");
   endtask

   task automatic t_busy_and_hold;
      logic [1:0]        k0;
      logic [PROC_W-1:0] d0;
      logic [ADDR_W-1:0] a0;
      send_req(1, 0, 5);
      expect_msg(K_REPLY, 0, 5, 0, "R3 second block reply");
      send_req(0, 1, 5);
      chk(!req_ready, "R8 busy after accept", int'(req_ready), 0);
      chk(msg_valid, "R9 fetch offered", int'(msg_valid), 1);
      k0 = msg_kind;
      d0 = msg_dst;
      a0 = msg_addr;
      repeat (3) @(negedge clk);
      chk(msg_valid, "R9 valid held", int'(msg_valid), 1);
      chk(msg_kind == k0 && msg_dst == d0 && msg_addr == a0, "R9 fields held",
          int'({msg_kind, msg_dst, msg_addr}), int'({k0, d0, a0}));
      chk(!req_ready, "R8 still busy", int'(req_ready), 0);
      expect_msg(K_FETCH, 0, 5, 0, "R5 second fetch");
      send_rsp(0, 0, 5, 8'h19);
      expect_msg(K_REPLY, 1, 5, 8'h19, "R5 second reply");
      check_entry(5, S_SHR, 4'b0011, 8'h19, "R5 second entry");
      check_entry(3, S_EXC, 4'b0010, 8'hC3, "R2 other block untouched");
      @(negedge clk);
      chk(req_ready, "R8 ready again", int'(req_ready), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_uncached();
      t_write_exclusive();
      t_read_exclusive();
      t_read_shared();
      t_write_shared();
      t_idle_writeback();
      t_read_uncached_and_sole_sharer();
      t_busy_and_hold();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule